// File: doc/BRIEF.md
# Dual-Write Register File with Atomic Exchange

This block is the architectural register store of a small processor datapath. It has two combinational read ports for operand fetch and two synchronous write ports. The second write port exists so that one instruction can exchange the contents of two registers on a single clock edge. No temporary register and no three-step move sequence are needed, and no cycle ever shows a half-finished exchange.

Each cycle the write side is classified into one of four operation kinds: `OP_IDLE` (nothing requested), `OP_WRITE` (an ordinary single write), `OP_SWAP` (an exchange of two distinct registers) and `OP_SWAP_SAME` (an exchange that names one register twice and so changes nothing). An exchange has priority over an ordinary write requested in the same cycle. The ordinary write is then dropped, and a collision flag is raised in that cycle. When the `ZERO_R0` parameter is set, register 0 always reads as zero and every write aimed at it is discarded.

Top module: `regx_swap_file`

## Requirements
- R1: While `rst_n` is low, every register is cleared to zero, and after reset every address reads zero.
- R2: `rd_data_a` and `rd_data_b` show, in the same cycle and combinationally, the contents of the registers addressed by `rd_addr_a` and `rd_addr_b`. Any pair of addresses is allowed, including equal ones.
- R3: With `wr_en` high and `swap_en` low, the register at `wr_addr` holds `wr_data` after the next rising edge.
- R4: With `swap_en` high and `swap_x` different from `swap_y`, after the next rising edge register `swap_x` holds the old contents of `swap_y` and register `swap_y` holds the old contents of `swap_x`. Both change on the same edge.
- R5: An exchange with `swap_x` equal to `swap_y` leaves every register unchanged. The two write ports never target the same register in one cycle.
- R6: When `wr_en` and `swap_en` are both high, the exchange is performed, the ordinary write has no effect on any register, and `collide` is high in that cycle.
- R7: `collide` is low in any cycle where `wr_en` and `swap_en` are not both high.
- R8: With `ZERO_R0` = 1, address 0 always reads zero and writes to it are discarded. An exchange between register 0 and register k therefore sets register k to zero.
- R9: A read of a register in the cycle it is written returns the value it held before that edge. There is no write-through bypass.
- R10: Registers not named by the performed write or exchange keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_addr_a | input | AW | Read port A address |
| rd_addr_b | input | AW | Read port B address |
| rd_data_a | output | WIDTH | Read port A data |
| rd_data_b | output | WIDTH | Read port B data |
| wr_en | input | 1 | Ordinary write request |
| wr_addr | input | AW | Ordinary write address |
| wr_data | input | WIDTH | Ordinary write data |
| swap_en | input | 1 | Exchange request |
| swap_x | input | AW | First register of the exchange |
| swap_y | input | AW | Second register of the exchange |
| collide | output | 1 | High when an ordinary write is dropped in favour of an exchange |

## Verification
The assertions assume `DEPTH` is a power of two, so every address value names a real register. They also assume that request inputs hold steady between clock edges once reset is released. The stimulus meets both conditions: it uses the default 16-entry file and changes inputs only on falling edges. The random phase draws addresses from the full range with no filtering, so self-exchanges, exchanges involving register 0, and collisions whose dropped write targets an exchanged register all occur naturally and stay inside those assumptions.

// File: rtl/regx_pkg.sv
package regx_pkg;
    typedef enum logic [1:0] {
        OP_IDLE      = 2'd0,
        OP_WRITE     = 2'd1,
        OP_SWAP      = 2'd2,
        OP_SWAP_SAME = 2'd3
    } regx_op_e;
endpackage

// File: rtl/regx_wr_arb.sv
module regx_wr_arb
    import regx_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int AW    = 4
) (
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             swap_en,
    input  logic [AW-1:0]    swap_x,
    input  logic [AW-1:0]    swap_y,
    input  logic [WIDTH-1:0] x_val,
    input  logic [WIDTH-1:0] y_val,
    output logic             p0_en,
    output logic [AW-1:0]    p0_addr,
    output logic [WIDTH-1:0] p0_data,
    output logic             p1_en,
    output logic [AW-1:0]    p1_addr,
    output logic [WIDTH-1:0] p1_data,
    output logic             collide
);
    regx_op_e op;

    // classify the request
    always_comb begin
        if (swap_en)
            op = (swap_x == swap_y) ? OP_SWAP_SAME : OP_SWAP;
        else if (wr_en)
            op = OP_WRITE;
        else
            op = OP_IDLE;
    end

    // drive both write ports from the classification
    always_comb begin
        p0_en   = 1'b0;
        p0_addr = '0;
        p0_data = '0;
        p1_en   = 1'b0;
        p1_addr = '0;
        p1_data = '0;
        unique case (op)
            OP_IDLE, OP_SWAP_SAME: ;
            OP_WRITE: begin
                p0_en   = 1'b1;
                p0_addr = wr_addr;
                p0_data = wr_data;
            end
            OP_SWAP: begin
                p0_en   = 1'b1;
                p0_addr = swap_x;
                p0_data = y_val;
                p1_en   = 1'b1;
                p1_addr = swap_y;
                p1_data = x_val;
            end
            default: ;
        endcase
    end

    assign collide = wr_en && swap_en;
endmodule

// File: rtl/regx_bank.sv
module regx_bank #(
    parameter int WIDTH   = 32,
    parameter int DEPTH   = 16,
    parameter bit ZERO_R0 = 1'b1,
    parameter int AW      = 4,
    parameter int NRD     = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     p0_en,
    input  logic [AW-1:0]            p0_addr,
    input  logic [WIDTH-1:0]         p0_data,
    input  logic                     p1_en,
    input  logic [AW-1:0]            p1_addr,
    input  logic [WIDTH-1:0]         p1_data,
    input  logic [NRD-1:0][AW-1:0]   rd_addr,
    output logic [NRD-1:0][WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (!(ZERO_R0 && i == 0)) begin
                    if (p0_en && p0_addr == AW'(i))
                        cells[i] <= p0_data;
                    else if (p1_en && p1_addr == AW'(i))
                        cells[i] <= p1_data;
                end
            end
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        if (ZERO_R0) begin : g_zero
            assign rd_data[g] = (rd_addr[g] == '0) ? '0 : cells[rd_addr[g]];
        end else begin : g_plain
            assign rd_data[g] = cells[rd_addr[g]];
        end
    end

    a_r3_port0_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_en && !(ZERO_R0 && p0_addr == '0)) |=> cells[$past(p0_addr)] == $past(p0_data));

    a_r4_port1_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (p1_en && !(ZERO_R0 && p1_addr == '0)) |=> cells[$past(p1_addr)] == $past(p1_data));

    a_r5_ports_apart: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_en && p1_en) |-> (p0_addr != p1_addr));
endmodule

// File: rtl/regx_swap_file.sv
module regx_swap_file #(
    parameter int WIDTH   = 32,
    parameter int DEPTH   = 16,
    parameter bit ZERO_R0 = 1'b1,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    rd_addr_a,
    input  logic [AW-1:0]    rd_addr_b,
    output logic [WIDTH-1:0] rd_data_a,
    output logic [WIDTH-1:0] rd_data_b,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             swap_en,
    input  logic [AW-1:0]    swap_x,
    input  logic [AW-1:0]    swap_y,
    output logic             collide
);
    localparam int NRD = 4;

    logic                      p0_en, p1_en;
    logic [AW-1:0]             p0_addr, p1_addr;
    logic [WIDTH-1:0]          p0_data, p1_data;
    logic [NRD-1:0][AW-1:0]    rd_addr;
    logic [NRD-1:0][WIDTH-1:0] rd_data;

    assign rd_addr   = {swap_y, swap_x, rd_addr_b, rd_addr_a};
    assign rd_data_a = rd_data[0];
    assign rd_data_b = rd_data[1];

    regx_wr_arb #(.WIDTH(WIDTH), .AW(AW)) u_arb (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .swap_en (swap_en),
        .swap_x  (swap_x),
        .swap_y  (swap_y),
        .x_val   (rd_data[2]),
        .y_val   (rd_data[3]),
        .p0_en   (p0_en),
        .p0_addr (p0_addr),
        .p0_data (p0_data),
        .p1_en   (p1_en),
        .p1_addr (p1_addr),
        .p1_data (p1_data),
        .collide (collide)
    );

    regx_bank #(.WIDTH(WIDTH), .DEPTH(DEPTH), .ZERO_R0(ZERO_R0), .AW(AW), .NRD(NRD)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .p0_en   (p0_en),
        .p0_addr (p0_addr),
        .p0_data (p0_data),
        .p1_en   (p1_en),
        .p1_addr (p1_addr),
        .p1_data (p1_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    a_r4_swap_exchange: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_en && swap_x != swap_y && swap_x != '0 && swap_y != '0)
        |=> (u_bank.cells[$past(swap_x)] == $past(u_bank.cells[swap_y]))
         && (u_bank.cells[$past(swap_y)] == $past(u_bank.cells[swap_x])));

    a_r5_self_swap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_en && swap_x == swap_y)
        |=> u_bank.cells[$past(swap_x)] == $past(u_bank.cells[swap_x]));

    a_r6_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && swap_en && wr_addr != swap_x && wr_addr != swap_y)
        |=> u_bank.cells[$past(wr_addr)] == $past(u_bank.cells[wr_addr]));

    if (ZERO_R0) begin : g_zero_chk
        a_r8_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_addr_a == '0) |-> (rd_data_a == '0));
    end
endmodule

// File: tb/regx_swap_file_bench.sv
`timescale 1ns/1ps
module regx_swap_file_bench;
    localparam int W = 32;
    localparam int D = 16;
    localparam int A = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [A-1:0] rd_addr_a = '0, rd_addr_b = '0;
    logic [W-1:0] rd_data_a, rd_data_b;
    logic         wr_en = 1'b0;
    logic [A-1:0] wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic         swap_en = 1'b0;
    logic [A-1:0] swap_x = '0, swap_y = '0;
    logic         collide;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] model [D];

    always #2.5 clk = ~clk;

    regx_swap_file #(.WIDTH(W), .DEPTH(D), .ZERO_R0(1'b1)) u_regx_swap_file (
        .clk(clk), .rst_n(rst_n),
        .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
        .rd_data_a(rd_data_a), .rd_data_b(rd_data_b),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .swap_en(swap_en), .swap_x(swap_x), .swap_y(swap_y),
        .collide(collide)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one cycle: drive at falling edge, compare just after, update model at rising edge
    task automatic cycle(input logic we, input logic [A-1:0] wa, input logic [W-1:0] wd,
                         input logic se, input logic [A-1:0] sx, input logic [A-1:0] sy,
                         input logic [A-1:0] ra, input logic [A-1:0] rb, input string tag);
        logic [W-1:0] t;
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd;
        swap_en = se; swap_x = sx; swap_y = sy;
        rd_addr_a = ra; rd_addr_b = rb;
        #1;
        check({tag, " rd_a"}, rd_data_a, model[ra]);
        check({tag, " rd_b"}, rd_data_b, model[rb]);
        check((we && se) ? "R6 collide" : "R7 collide", {31'd0, collide}, {31'd0, we && se});
        @(posedge clk);
        if (se) begin
            if (sx != sy) begin
                t = model[sx]; model[sx] = model[sy]; model[sy] = t;
            end
        end else if (we) begin
            model[wa] = wd;
        end
        model[0] = '0;
    endtask

    task automatic peek(input logic [A-1:0] a, input string tag);
        cycle(1'b0, '0, '0, 1'b0, '0, '0, a, a, tag);
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < D; i++) model[i] = '0;
        for (int i = 0; i < D; i++) model[i] = 32'hDEAD_0000 + i;
        // reset: model cleared, check every address reads zero (R1)
        for (int i = 0; i < D; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        for (int i = 0; i < D; i++) peek(A'(i), "R1");

        // ordinary writes (R3), then readback
        for (int i = 1; i < D; i++) cycle(1'b1, A'(i), 32'h1000_0000 + 32'(i * 17), 1'b0, '0, '0, '0, '0, "R3");
        for (int i = 0; i < D; i++) peek(A'(i), "R3");

        // exchange of two registers (R4), neighbour untouched (R10)
        cycle(1'b0, '0, '0, 1'b1, 4'd3, 4'd7, 4'd3, 4'd7, "R4");
        cycle(1'b0, '0, '0, 1'b0, '0, '0, 4'd3, 4'd7, "R4");
        check("R4 reg3", rd_data_a, 32'h1000_0000 + 32'(7 * 17));
        check("R4 reg7", rd_data_b, 32'h1000_0000 + 32'(3 * 17));
        peek(4'd5, "R10");

        // self exchange (R5)
        cycle(1'b0, '0, '0, 1'b1, 4'd4, 4'd4, 4'd4, 4'd4, "R5");
        peek(4'd4, "R5");
        check("R5 reg4", rd_data_a, 32'h1000_0000 + 32'(4 * 17));

        // collision: write to 9 dropped, swap 1/2 done (R6)
        cycle(1'b1, 4'd9, 32'hBAD0_BAD0, 1'b1, 4'd1, 4'd2, 4'd9, 4'd1, "R6");
        cycle(1'b0, '0, '0, 1'b0, '0, '0, 4'd9, 4'd1, "R6");
        check("R6 reg9", rd_data_a, 32'h1000_0000 + 32'(9 * 17));

        // register 0 pinned (R8)
        cycle(1'b1, 4'd0, 32'hFFFF_FFFF, 1'b0, '0, '0, '0, '0, "R8");
        peek(4'd0, "R8");
        check("R8 reg0", rd_data_a, '0);
        cycle(1'b0, '0, '0, 1'b1, 4'd0, 4'd6, '0, 4'd6, "R8");
        peek(4'd6, "R8");
        check("R8 reg6", rd_data_a, '0);

        // read during write returns old value (R9)
        cycle(1'b1, 4'd11, 32'h5555_AAAA, 1'b0, '0, '0, 4'd11, 4'd11, "R9");
        peek(4'd11, "R9");
        check("R9 reg11", rd_data_a, 32'h5555_AAAA);

        // random traffic (R2, R10)
        for (int n = 0; n < 3000; n++) begin
            cycle(($urandom % 3) == 0, A'($urandom), $urandom, ($urandom % 3) == 0,
                  A'($urandom), A'($urandom), A'($urandom), A'($urandom), "R2");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule